// File: doc/BRIEF.md
# Two-Wire Bus Slave Protocol Engine

This block is the bit-level slave side of an I2C-style two-wire bus. A fast system clock oversamples SCL and SDA. Each line passes through a synchronizer and a spike filter. A condition detector finds START, repeated START and STOP. A frame state machine then receives an address byte, a command byte and data bytes, acknowledges them, and hands each complete byte to a register controller as a one-cycle pulse. The block never drives SDA high. It only asserts an enable that pulls the line low, as an open-drain driver would.

The 7-bit slave address is a fixed `010` prefix followed by four strap inputs, with the straps' bit 3 sent first. A read works in two steps. First the master sends a write-addressed frame with a command byte. Then it issues a repeated START and sends the address with the read bit set. The engine asks the controller for one byte and shifts that byte out MSB first.

Top module: `tws_slave`

## Requirements
- R1: After reset `sda_oe_o`, `cmd_vld_o`, `wr_vld_o` and `rd_req_o` are all 0.
- R2: An address byte equal to {0,1,0,strap_i[3:0],rw}, sent MSB first after a START, is acknowledged: SDA is held low for the whole high phase of the 9th clock. Any other address is not acknowledged, and the rest of the frame is ignored until the next START or STOP.
- R3: The byte after an acknowledged write address is the command byte. `cmd_vld_o` pulses for one cycle on the 8th SCL rise of that byte, `cmd_byte_o` carries the byte MSB first, and the byte is acknowledged.
- R4: Every byte after the command byte in a write frame is acknowledged. For each one, `wr_vld_o` pulses once with `wr_byte_o` holding the byte, on the byte's 8th SCL rise.
- R5: A STOP (SDA rising while SCL is high) at any point aborts the frame, and a partly shifted byte produces no pulse. The engine then idles with SDA released, and the command from the aborted frame no longer counts for a later read.
- R6: A STOP in the same SCL high phase as the START that opened it is ignored. The frame goes on, and the next byte is taken as the address.
- R7: After a command byte and a repeated START, a matching address with rw=1 is acknowledged and `rd_req_o` pulses on its 8th rise. `rd_data_i` is sampled when the acknowledge clock falls and driven out MSB first. The SDA enable changes only while SCL is low.
- R8: A read address (rw=1) that does not follow a command byte in the same frame is not acknowledged. This applies after a STOP and after a completed read.
- R9: A repeated START after a data byte starts a fresh address phase. Chained write frames each deliver their bytes.
- R10: A pulse shorter than `FILT_CYC` system clocks on SCL or SDA has no effect. An SDA dip while SCL is idle-high starts no frame, and an SCL dip inside a bit adds no bit.
- R11: The all-zero general call address is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 4 | Low four address bits |
| rd_data_i | input | 8 | Byte to return in a read, from the register controller |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| cmd_vld_o | output | 1 | One-cycle pulse: command byte received |
| cmd_byte_o | output | 8 | Last command byte |
| wr_vld_o | output | 1 | One-cycle pulse: write data byte received |
| wr_byte_o | output | 8 | Last write data byte |
| rd_req_o | output | 1 | One-cycle pulse: read address accepted, present `rd_data_i` |

## Verification
Some properties hold on every cycle and are checked by the assertions. The SDA enable changes only while the filtered SCL is low. The three byte pulses never coincide. A write pulse appears only in the data phase. A STOP leaves the engine idle with SDA released, and the bit counter stays within one byte plus acknowledge. The filter moves its output only after the synchronized line has disagreed with it.

Other behaviours depend on a whole frame and are shown only by the bench scenarios. These are address matching against the straps, acknowledge placement, the read turnaround with its byte order, aborts by STOP, the ignored STOP right after a START, chained frames, and glitch rejection.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 7;
  localparam int PREFIX_W = 3;
  localparam int STRAP_W  = ADDR_W - PREFIX_W;
  localparam int BITCNT_W = $clog2(BYTE_W + 2);
  localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } tws_state_e;
endpackage

// File: rtl/tws_filter.sv
module tws_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw_s;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   filt_q, filt_d;

  assign raw_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (raw_s == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      filt_d = raw_s;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  // R10
  filt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(raw_s) != $past(filt_q)));

endmodule

// File: rtl/tws_cond.sv
module tws_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;
  logic start_hi_q, start_hi_d;
  logic stop_raw;

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_raw = scl_f & scl_p & ~sda_p & sda_f;
  assign stop_ev  = stop_raw & ~start_hi_q;

  always_comb begin
    start_hi_d = start_hi_q;
    if (start_ev)      start_hi_d = 1'b1;
    else if (scl_fall) start_hi_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p      <= 1'b1;
      sda_p      <= 1'b1;
      start_hi_q <= 1'b0;
    end else begin
      scl_p      <= scl_f;
      sda_p      <= sda_f;
      start_hi_q <= start_hi_d;
    end
  end

endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
  import tws_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_f,
  input  logic               sda_f,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic               cmd_vld_o,
  output logic [BYTE_W-1:0]  cmd_byte_o,
  output logic               wr_vld_o,
  output logic [BYTE_W-1:0]  wr_byte_o,
  output logic               rd_req_o
);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);
  localparam logic [BITCNT_W-1:0] ACK_SLOT = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0] ACK_DONE = BITCNT_W'(BYTE_W + 1);

  tws_state_e          state_q, state_d;
  logic [BITCNT_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-2:0]   sh_q, sh_d;
  logic [BYTE_W-2:0]   tx_q, tx_d;
  logic                oe_q, oe_d;
  logic                ack_q, ack_d;
  logic                cmd_seen_q, cmd_seen_d;
  logic                cmd_vld_q, cmd_vld_d;
  logic [BYTE_W-1:0]   cmd_byte_q, cmd_byte_d;
  logic                wr_vld_q, wr_vld_d;
  logic [BYTE_W-1:0]   wr_byte_q, wr_byte_d;
  logic                rd_req_q, rd_req_d;
  logic [BYTE_W-1:0]   full_byte;
  logic                active;
  logic                addr_hit;

  assign full_byte = {sh_q, sda_f};
  assign active    = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                     (state_q == ST_WDATA) || (state_q == ST_RDATA);
  assign addr_hit  = (full_byte[BYTE_W-1:1] == {ADDR_PREFIX, strap_i}) &&
                     (!full_byte[0] || cmd_seen_q);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    tx_d       = tx_q;
    oe_d       = oe_q;
    ack_d      = ack_q;
    cmd_seen_d = cmd_seen_q;
    cmd_byte_d = cmd_byte_q;
    wr_byte_d  = wr_byte_q;
    cmd_vld_d  = 1'b0;
    wr_vld_d   = 1'b0;
    rd_req_d   = 1'b0;

    if (stop_ev) begin
      state_d    = ST_IDLE;
      cnt_d      = '0;
      oe_d       = 1'b0;
      ack_d      = 1'b0;
      cmd_seen_d = 1'b0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      ack_d   = 1'b0;
    end else if (active && scl_rise) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < ACK_SLOT) sh_d = full_byte[BYTE_W-2:0];
      if (cnt_q == LAST_BIT) begin
        case (state_q)
          ST_ADDR: begin
            if (addr_hit) begin
              ack_d    = 1'b1;
              rd_req_d = full_byte[0];
            end else begin
              state_d = ST_WAIT;
              cnt_d   = '0;
            end
          end
          ST_CMD: begin
            cmd_byte_d = full_byte;
            cmd_vld_d  = 1'b1;
            cmd_seen_d = 1'b1;
            ack_d      = 1'b1;
          end
          ST_WDATA: begin
            wr_byte_d = full_byte;
            wr_vld_d  = 1'b1;
            ack_d     = 1'b1;
          end
          default: ack_d = 1'b0;
        endcase
      end
    end else if (active && scl_fall) begin
      if (cnt_q == ACK_SLOT) begin
        oe_d = ack_q;
      end else if (cnt_q == ACK_DONE) begin
        oe_d  = 1'b0;
        cnt_d = '0;
        ack_d = 1'b0;
        case (state_q)
          ST_ADDR: begin
            if (sh_q[0]) begin
              state_d    = ST_RDATA;
              tx_d       = rd_data_i[BYTE_W-2:0];
              oe_d       = ~rd_data_i[BYTE_W-1];
              cmd_seen_d = 1'b0;
            end else begin
              state_d = ST_CMD;
            end
          end
          ST_CMD:   state_d = ST_WDATA;
          ST_WDATA: state_d = ST_WDATA;
          default:  state_d = ST_WAIT;
        endcase
      end else if (state_q == ST_RDATA && cnt_q != '0) begin
        oe_d = ~tx_q[BYTE_W-2];
        tx_d = {tx_q[BYTE_W-3:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      oe_q       <= 1'b0;
      ack_q      <= 1'b0;
      cmd_seen_q <= 1'b0;
      cmd_vld_q  <= 1'b0;
      cmd_byte_q <= '0;
      wr_vld_q   <= 1'b0;
      wr_byte_q  <= '0;
      rd_req_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      tx_q       <= tx_d;
      oe_q       <= oe_d;
      ack_q      <= ack_d;
      cmd_seen_q <= cmd_seen_d;
      cmd_vld_q  <= cmd_vld_d;
      cmd_byte_q <= cmd_byte_d;
      wr_vld_q   <= wr_vld_d;
      wr_byte_q  <= wr_byte_d;
      rd_req_q   <= rd_req_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign cmd_vld_o  = cmd_vld_q;
  assign cmd_byte_o = cmd_byte_q;
  assign wr_vld_o   = wr_vld_q;
  assign wr_byte_o  = wr_byte_q;
  assign rd_req_o   = rd_req_q;

  // R7
  oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl_f);

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_vld_q, wr_vld_q, rd_req_q}));

  // R4
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_q |-> (state_q == ST_WDATA));

  // R5
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!oe_q && state_q == ST_IDLE));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ACK_DONE);

endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic               cmd_vld_o,
  output logic [BYTE_W-1:0]  cmd_byte_o,
  output logic               wr_vld_o,
  output logic [BYTE_W-1:0]  wr_byte_o,
  output logic               rd_req_o
);
  localparam int LINES = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] raw_w, filt_w;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    tws_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC)
    ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_w[g]),
      .filt_o(filt_w[g])
    );
  end

  tws_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (filt_w[SCL_IX]),
    .sda_f   (filt_w[SDA_IX]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  tws_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (filt_w[SCL_IX]),
    .sda_f     (filt_w[SDA_IX]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .strap_i   (strap_i),
    .rd_data_i (rd_data_i),
    .sda_oe_o  (sda_oe_o),
    .cmd_vld_o (cmd_vld_o),
    .cmd_byte_o(cmd_byte_o),
    .wr_vld_o  (wr_vld_o),
    .wr_byte_o (wr_byte_o),
    .rd_req_o  (rd_req_o)
  );

endmodule

// File: tb/tws_slave_bench.sv
module tws_slave_bench;
  localparam int H = 50;
  localparam int Q = H / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       scl_m, sda_m, scl_gl, sda_gl;
  logic [3:0] strap;
  logic [7:0] rd_data;
  logic       sda_oe, cmd_vld, wr_vld, rd_req;
  logic [7:0] cmd_byte, wr_byte;
  wire        sda_line = sda_m & ~sda_oe;

  tws_slave u_tws_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m & ~scl_gl),
    .sda_i     (sda_line & ~sda_gl),
    .strap_i   (strap),
    .rd_data_i (rd_data),
    .sda_oe_o  (sda_oe),
    .cmd_vld_o (cmd_vld),
    .cmd_byte_o(cmd_byte),
    .wr_vld_o  (wr_vld),
    .wr_byte_o (wr_byte),
    .rd_req_o  (rd_req)
  );

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0, n_wr = 0, n_rd = 0, oe_bad = 0;
  logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;
  logic oe_prev = 1'b0;
  bit done = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_vld) begin n_cmd++; last_cmd = cmd_byte; end
      if (wr_vld)  begin n_wr++;  last_wr  = wr_byte;  end
      if (rd_req)  n_rd++;
      if (sda_oe !== oe_prev && scl_m) oe_bad++;
    end
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_b(input logic [3:0] s, input logic rw);
    return {3'b010, s, rw};
  endfunction

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    wcyc(Q); sda_m = 1'b1; wcyc(Q); scl_m = 1'b1; wcyc(Q);
    sda_m = 1'b0; wcyc(Q); scl_m = 1'b0;
  endtask

  task automatic bstop();
    wcyc(Q); sda_m = 1'b0; wcyc(Q); scl_m = 1'b1; wcyc(Q);
    sda_m = 1'b1; wcyc(H);
  endtask

  task automatic bbit(input logic b, input bit gl, output logic smp);
    wcyc(Q); sda_m = b; wcyc(Q); scl_m = 1'b1;
    wcyc(Q / 2);
    if (gl) begin scl_gl = 1'b1; wcyc(8); scl_gl = 1'b0; end
    wcyc(Q / 2);
    smp = sda_line;
    wcyc(Q); scl_m = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] b, input int gl_bit, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bbit(b[i], gl_bit == i, s);
    bbit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin bbit(1'b1, 1'b0, s); d[i] = s; end
    bbit(!mack, 1'b0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] d;
    int c0, w0, r0;
    int unsigned rnd;
    rnd = $urandom(32'h5eed);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; scl_gl = 1'b0; sda_gl = 1'b0;
    strap = 4'b1010; rd_data = 8'h00;
    wcyc(5); rst_n = 1'b1; wcyc(2);
    // R1 reset state
    check("R1 oe", sda_oe, 0);
    check("R1 pulses", {cmd_vld, wr_vld, rd_req}, 0);
    wcyc(40);

    // R2 R3 R4 directed write
    c0 = n_cmd; w0 = n_wr;
    bstart(); sbyte(addr_b(4'b1010, 0), -1, a0); sbyte(8'h15, -1, a1); sbyte(8'hA7, -1, a2); bstop();
    check("R2 addr ack", a0, 1);
    check("R3 cmd ack", a1, 1);
    check("R3 cmd pulse", n_cmd - c0, 1);
    check("R3 cmd byte", last_cmd, 8'h15);
    check("R4 data ack", a2, 1);
    check("R4 wr pulse", n_wr - w0, 1);
    check("R4 wr byte", last_wr, 8'hA7);

    // R2 mismatch ignored
    c0 = n_cmd;
    bstart(); sbyte(addr_b(4'b1011, 0), -1, a0); sbyte(8'h33, -1, a1); bstop();
    check("R2 mismatch nack", a0, 0);
    check("R2 mismatch ignored", {a1, 31'(n_cmd - c0)}, 0);

    // R11 general call
    bstart(); sbyte(8'h00, -1, a0); bstop();
    check("R11 general call nack", a0, 0);

    // R5 abort mid-byte, then R8 read without command
    w0 = n_wr;
    bstart(); sbyte(addr_b(4'b1010, 0), -1, a0); sbyte(8'h91, -1, a1);
    for (int i = 0; i < 4; i++) bbit(1'b0, 1'b0, d[0]);
    bstop();
    check("R5 abort no wr", n_wr - w0, 0);
    check("R5 oe released", sda_oe, 0);
    bstart(); sbyte(addr_b(4'b1010, 1), -1, a0); bstop();
    check("R8 read without cmd nack", a0, 0);

    // R7 directed read
    rd_data = 8'hC5; r0 = n_rd;
    bstart(); sbyte(addr_b(4'b1010, 0), -1, a0); sbyte(8'h90, -1, a1);
    bstart(); sbyte(addr_b(4'b1010, 1), -1, a2); rbyte(d, 1'b0); bstop();
    check("R7 read addr ack", a2, 1);
    check("R7 rd_req pulse", n_rd - r0, 1);
    check("R7 read data", d, 8'hC5);

    // R9 chained writes
    w0 = n_wr;
    bstart(); sbyte(addr_b(4'b1010, 0), -1, a0); sbyte(8'h01, -1, a1); sbyte(8'h5A, -1, a2);
    bstart(); sbyte(addr_b(4'b1010, 0), -1, a0); sbyte(8'h02, -1, a1); sbyte(8'h3C, -1, a2); bstop();
    check("R9 chained acks", {a0, a1, a2}, 3'b111);
    check("R9 two writes", n_wr - w0, 2);
    check("R9 last byte", last_wr, 8'h3C);

    // R6 STOP in same high as START is ignored
    c0 = n_cmd;
    wcyc(Q); sda_m = 1'b0; wcyc(Q); sda_m = 1'b1; wcyc(Q); scl_m = 1'b0;
    sbyte(addr_b(4'b1010, 0), -1, a0); sbyte(8'h77, -1, a1); bstop();
    check("R6 addr ack after illegal stop", a0, 1);
    check("R6 cmd byte", {31'(n_cmd - c0), 1'b0} | 32'(last_cmd == 8'h77), 3);

    // R10 SDA spike in idle starts nothing
    wcyc(Q); sda_gl = 1'b1; wcyc(8); sda_gl = 1'b0; wcyc(Q); scl_m = 1'b0;
    sbyte(addr_b(4'b1010, 0), -1, a0); bstop();
    check("R10 sda spike no frame", a0, 0);

    // R10 SCL spike within command byte
    bstart(); sbyte(addr_b(4'b1010, 0), -1, a0); sbyte(8'hB4, 3, a1); bstop();
    check("R10 scl spike cmd byte", last_cmd, 8'hB4);

    // random frames
    for (int k = 0; k < 12; k++) begin
      logic [3:0] tgt;
      logic [7:0] cb, db;
      logic match;
      strap = 4'($urandom);
      tgt = ($urandom % 4 == 0) ? 4'($urandom) : strap;
      match = (tgt == strap);
      cb = 8'($urandom); db = 8'($urandom); rd_data = 8'($urandom);
      c0 = n_cmd; w0 = n_wr; r0 = n_rd;
      if ($urandom % 2 == 0) begin
        bstart(); sbyte(addr_b(tgt, 0), -1, a0); sbyte(cb, -1, a1); sbyte(db, -1, a2); bstop();
        check("R2 rand addr ack", a0, match);
        check("R4 rand wr count", n_wr - w0, match ? 1 : 0);
        if (match) check("R4 rand wr byte", {last_cmd, last_wr}, {cb, db});
      end else begin
        bstart(); sbyte(addr_b(tgt, 0), -1, a0); sbyte(cb, -1, a1);
        bstart(); sbyte(addr_b(tgt, 1), -1, a2); rbyte(d, 1'b0); bstop();
        check("R7 rand read ack", {a0, a2}, {match, match});
        check("R7 rand rd_req", n_rd - r0, match ? 1 : 0);
        if (match) check("R7 rand read data", d, rd_data);
      end
    end

    check("R7 oe never changes with SCL high", oe_bad, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule